// File: doc/BRIEF.md
# Crystal Clock Loss Monitor Controller

This block watches an external crystal clock from the always-running ring-oscillator clock domain. While monitoring is live it asks for a system reset when the crystal clock has produced no edge for a short window of ring-oscillator cycles. Software arms monitoring by setting the low bit of a one-byte mode register. Once armed, monitoring stays armed until the next reset.

The controller also decides, cycle by cycle, whether monitoring is live. Monitoring pauses while the part sits in STOP mode. It also pauses while software holds the crystal stopped, and while the crystal stabilizes after either kind of restart. The stabilization wait comes from a small programmable setting. When that wait ends, monitoring resumes without any help from software.

The STOP sequence has its own rule. STOP is entered a fixed 17 ring-oscillator clocks after the request. Monitoring stays live during those clocks.

Top module: `clkmon_ctrl`

## Requirements
- R1: After reset, `mon_active` and `loss_rst_req` are both 0 and monitoring is disarmed.
- R2: A write (`cfg_wr`=1) with `cfg_wdata[0]`=1 arms monitoring. With no other gating active, `mon_active` is 1 from the clock after the write. The other data bits have no effect.
- R3: Once armed, monitoring can only be disarmed by reset. A later write with `cfg_wdata[0]`=0 leaves `mon_active` at 1.
- R4: A `stop_req` pulse accepted in the running state enters STOP 17 clocks after the request clock. `mon_active` stays 1 for those 17 clocks and reads 0 from the next one.
- R5: While in STOP, `mon_active` is 0. A crystal that stops toggling then raises no `loss_rst_req`.
- R6: A `stop_release` pulse in STOP starts the stabilization wait of 2^(4+`stab_sel`) clocks, during which `mon_active` stays 0. `mon_active` returns to 1 on the clock after the wait ends, with no software action.
- R7: The software crystal-stop bit is selected by `cpu_on_sub`. When it is 0, `xstop_main` is used. When it is 1, `xstop_sub` is used. The unselected bit is ignored. When the selected bit is 1, `mon_active` is 0 from the next clock, and a stopped crystal raises no request.
- R8: When the selected stop bit returns to 0, the same stabilization wait as in R6 runs and then monitoring resumes by itself. This also holds when arming happened while the crystal was stopped.
- R9: While `mon_active` is 1, `loss_rst_req` rises if no crystal edge is seen through the 2-flop synchronizer for 4 clocks. Once raised it stays at 1 until reset.
- R10: While the crystal keeps toggling faster than the loss window, `loss_rst_req` stays 0.
- R11: `stop_release` outside STOP is ignored. A second `stop_req` during STOP entry does not restart the 17-clock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ro | input | 1 | Ring-oscillator clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data; bit 0 arms monitoring |
| stop_req | input | 1 | Request to enter STOP mode (pulse) |
| stop_release | input | 1 | STOP release event (pulse) |
| xstop_main | input | 1 | Software crystal stop, used when the CPU runs on the ring oscillator |
| xstop_sub | input | 1 | Software crystal stop, used when the CPU runs on the subsystem clock |
| cpu_on_sub | input | 1 | CPU clock source: 1 = subsystem clock, 0 = ring oscillator |
| stab_sel | input | 2 | Stabilization time setting, wait = 2^(4+value) clocks |
| xtal_clk | input | 1 | Monitored crystal clock, asynchronous |
| mon_active | output | 1 | Monitoring is live |
| loss_rst_req | output | 1 | Sticky loss-of-clock reset request |

## Verification
The assertions assume that `stab_sel` is held steady while a stabilization wait is running. They also assume that the crystal, whenever it runs, toggles well inside the 4-clock window as seen after synchronization. The bench keeps to both assumptions. It changes `stab_sel` only while the block is idle. It runs the crystal with a 7 ns half period against a 10 ns ring clock, and it stops the crystal only when it means to test loss detection. All control inputs are changed half a clock away from the active edge, so every pulse lasts exactly one clock.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_ENTER = 2'd1,
        PWR_STOP  = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_o
);
    // chain[STAGES-1:0] synchronize, chain[STAGES] holds the previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign edge_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/clkmon_stop_seq.sv
module clkmon_stop_seq
    import clkmon_pkg::*;
#(
    parameter int STOP_DELAY = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic stop_release,
    output logic in_stop,
    output logic wake
);
    localparam int CNT_W = $clog2(STOP_DELAY + 1);

    typedef struct packed {
        pwr_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        wake  = 1'b0;
        case (seq_q.st)
            PWR_RUN: begin
                if (stop_req) begin
                    seq_d.st  = PWR_ENTER;
                    seq_d.cnt = CNT_W'(STOP_DELAY - 1);
                end
            end
            PWR_ENTER: begin
                if (seq_q.cnt == '0) seq_d.st  = PWR_STOP;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            PWR_STOP: begin
                if (stop_release) begin
                    seq_d.st = PWR_RUN;
                    wake     = 1'b1;
                end
            end
            default: seq_d.st = PWR_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: PWR_RUN, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign in_stop = (seq_q.st == PWR_STOP);
endmodule

// File: rtl/clkmon_stab_timer.sv
module clkmon_stab_timer #(
    parameter int SEL_W     = 2,
    parameter int STAB_BASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    output logic             busy
);
    localparam int CNT_W = STAB_BASE + (1 << SEL_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t             tmr_d, tmr_q;
    logic [CNT_W-1:0] span;

    always_comb begin
        span  = CNT_W'(1) << (STAB_BASE + int'(sel));
        tmr_d = tmr_q;
        if (load)                tmr_d.cnt = span;
        else if (tmr_q.cnt != 0) tmr_d.cnt = tmr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = (tmr_q.cnt != '0);
endmodule

// File: rtl/clkmon_loss_det.sv
module clkmon_loss_det #(
    parameter int LOSS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic edge_seen,
    output logic req
);
    localparam int CW = $clog2(LOSS_LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] idle;
        logic          req;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d = det_q;
        if (!live || edge_seen) begin
            det_d.idle = '0;
        end else begin
            if (det_q.idle != CW'(LOSS_LIMIT)) det_d.idle = det_q.idle + 1'b1;
            if (det_q.idle >= CW'(LOSS_LIMIT - 1)) det_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign req = det_q.req;
endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl #(
    parameter int STOP_DELAY = 17,
    parameter int SEL_W      = 2,
    parameter int STAB_BASE  = 4,
    parameter int LOSS_LIMIT = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_ro,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [7:0]       cfg_wdata,
    input  logic             stop_req,
    input  logic             stop_release,
    input  logic             xstop_main,
    input  logic             xstop_sub,
    input  logic             cpu_on_sub,
    input  logic [SEL_W-1:0] stab_sel,
    input  logic             xtal_clk,
    output logic             mon_active,
    output logic             loss_rst_req
);
    typedef struct packed {
        logic en;
        logic xstop;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic xstop_sel, restart, stab_load;
    logic in_stop_w, wake_w, stab_busy_w, xedge_w, en_w;

    clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_ro), .rst_n(rst_n), .async_in(xtal_clk), .edge_o(xedge_w)
    );

    clkmon_stop_seq #(.STOP_DELAY(STOP_DELAY)) u_seq (
        .clk(clk_ro), .rst_n(rst_n), .stop_req(stop_req),
        .stop_release(stop_release), .in_stop(in_stop_w), .wake(wake_w)
    );

    clkmon_stab_timer #(.SEL_W(SEL_W), .STAB_BASE(STAB_BASE)) u_stab (
        .clk(clk_ro), .rst_n(rst_n), .load(stab_load), .sel(stab_sel),
        .busy(stab_busy_w)
    );

    clkmon_loss_det #(.LOSS_LIMIT(LOSS_LIMIT)) u_loss (
        .clk(clk_ro), .rst_n(rst_n), .live(mon_active), .edge_seen(xedge_w),
        .req(loss_rst_req)
    );

    always_comb begin
        xstop_sel = cpu_on_sub ? xstop_sub : xstop_main;
        restart   = ctl_q.xstop & ~xstop_sel;
        stab_load = wake_w | restart;
        ctl_d     = ctl_q;
        ctl_d.en    = ctl_q.en | (cfg_wr & cfg_wdata[0]);
        ctl_d.xstop = xstop_sel;
    end

    always_ff @(posedge clk_ro or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en_w       = ctl_q.en;
    assign mon_active = ctl_q.en & ~in_stop_w & ~ctl_q.xstop & ~stab_busy_w;
endmodule

// File: rtl/clkmon_ctrl_chk.sv
module clkmon_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_set,
    input logic en_q,
    input logic in_stop,
    input logic stab_busy,
    input logic mon_active,
    input logic loss_rst_req
);
    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_set |=> en_q); // R2
    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q); // R3
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_stop |-> !mon_active); // R5
    AST_STAB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stab_busy |-> !mon_active); // R6
    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        loss_rst_req |=> loss_rst_req); // R9
    AST_REQ_FROM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_rst_req) |-> $past(mon_active)); // R9
endmodule

bind clkmon_ctrl clkmon_ctrl_chk u_chk (
    .clk(clk_ro), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_set(cfg_wdata[0]),
    .en_q(en_w), .in_stop(in_stop_w), .stab_busy(stab_busy_w),
    .mon_active(mon_active), .loss_rst_req(loss_rst_req)
);

// File: tb/clkmon_ctrl_bench.sv
`timescale 1ns/1ps
module clkmon_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk_ro = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       stop_req = 1'b0, stop_release = 1'b0;
    logic       xstop_main = 1'b0, xstop_sub = 1'b0, cpu_on_sub = 1'b0;
    logic [1:0] stab_sel = 2'd0;
    logic       xtal_clk = 1'b0;
    logic       xtal_run = 1'b1;
    logic       mon_active, loss_rst_req;

    int checks = 0;
    int fails  = 0;

    clkmon_ctrl u_clkmon_ctrl (
        .clk_ro(clk_ro), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .stop_req(stop_req), .stop_release(stop_release),
        .xstop_main(xstop_main), .xstop_sub(xstop_sub), .cpu_on_sub(cpu_on_sub),
        .stab_sel(stab_sel), .xtal_clk(xtal_clk),
        .mon_active(mon_active), .loss_rst_req(loss_rst_req)
    );

    always #(CLK_PERIOD/2) clk_ro = ~clk_ro;

    initial begin
        forever begin
            #7;
            if (xtal_run) xtal_clk = ~xtal_clk;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_ro);
    endtask

    task automatic do_reset();
        @(negedge clk_ro);
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = 8'h00;
        stop_req = 1'b0; stop_release = 1'b0;
        xstop_main = 1'b0; xstop_sub = 1'b0; cpu_on_sub = 1'b0;
        stab_sel = 2'd0; xtal_run = 1'b1;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic write_cfg(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        cycles(1);
        cfg_wr = 1'b0; cfg_wdata = 8'h00;
    endtask

    task automatic t_reset_and_arm();
        do_reset();
        chk(mon_active, 1'b0, "R1 mon_active after reset");
        chk(loss_rst_req, 1'b0, "R1 loss_rst_req after reset");
        write_cfg(8'hFE);
        cycles(2);
        chk(mon_active, 1'b0, "R2 upper bits do not arm");
        write_cfg(8'h01);
        chk(mon_active, 1'b1, "R2 armed one clock after write");
        write_cfg(8'h00);
        cycles(3);
        chk(mon_active, 1'b1, "R3 zero write ignored");
        stop_release = 1'b1;
        cycles(1);
        stop_release = 1'b0;
        cycles(5);
        chk(mon_active, 1'b1, "R11 release outside STOP ignored");
    endtask

    task automatic t_stop_cycle();
        stab_sel = 2'd1;
        stop_req = 1'b1;
        cycles(1);
        stop_req = 1'b0;
        cycles(3);
        stop_req = 1'b1;
        cycles(1);
        stop_req = 1'b0;
        cycles(12);
        chk(mon_active, 1'b1, "R4 live through STOP entry");
        chk(mon_active, 1'b1, "R11 second request did not restart");
        cycles(1);
        chk(mon_active, 1'b0, "R4 suspended once STOP entered");
        xtal_run = 1'b0;
        cycles(20);
        chk(loss_rst_req, 1'b0, "R5 no request in STOP");
        chk(mon_active, 1'b0, "R5 suspended in STOP");
        xtal_run = 1'b1;
        cycles(3);
        stop_release = 1'b1;
        cycles(1);
        stop_release = 1'b0;
        chk(mon_active, 1'b0, "R6 suspended at release");
        cycles(31);
        chk(mon_active, 1'b0, "R6 suspended to end of wait");
        cycles(1);
        chk(mon_active, 1'b1, "R6 auto resume after wait");
        cycles(40);
        chk(loss_rst_req, 1'b0, "R10 running crystal gives no request");
        stab_sel = 2'd0;
    endtask

    task automatic t_sw_stop();
        xstop_sub = 1'b1;
        cycles(3);
        chk(mon_active, 1'b1, "R7 unselected sub bit ignored");
        xstop_sub = 1'b0;
        xstop_main = 1'b1;
        cycles(1);
        chk(mon_active, 1'b0, "R7 main bit suspends");
        xtal_run = 1'b0;
        cycles(20);
        chk(loss_rst_req, 1'b0, "R7 no request while sw-stopped");
        xtal_run = 1'b1;
        cycles(3);
        xstop_main = 1'b0;
        cycles(16);
        chk(mon_active, 1'b0, "R8 suspended during wait");
        cycles(1);
        chk(mon_active, 1'b1, "R8 auto resume after restart");
        cpu_on_sub = 1'b1;
        xstop_main = 1'b1;
        cycles(3);
        chk(mon_active, 1'b1, "R7 unselected main bit ignored");
        xstop_sub = 1'b1;
        cycles(1);
        chk(mon_active, 1'b0, "R7 sub bit suspends");
        xstop_sub = 1'b0;
        cycles(17);
        chk(mon_active, 1'b1, "R8 resume after sub restart");
        xstop_main = 1'b0;
        cpu_on_sub = 1'b0;
    endtask

    task automatic t_arm_while_stopped();
        do_reset();
        xstop_main = 1'b1;
        cycles(1);
        write_cfg(8'h01);
        cycles(2);
        chk(mon_active, 1'b0, "R8 armed but crystal stopped");
        xstop_main = 1'b0;
        cycles(16);
        chk(mon_active, 1'b0, "R8 wait after arm-while-stopped");
        cycles(1);
        chk(mon_active, 1'b1, "R8 live after arm-while-stopped");
    endtask

    task automatic t_loss();
        cycles(30);
        chk(loss_rst_req, 1'b0, "R10 no request with clock present");
        xtal_run = 1'b0;
        cycles(10);
        chk(loss_rst_req, 1'b1, "R9 request on lost clock");
        xtal_run = 1'b1;
        cycles(10);
        chk(loss_rst_req, 1'b1, "R9 request sticky");
        do_reset();
        chk(loss_rst_req, 1'b0, "R1 request cleared by reset");
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_and_arm();
        t_stop_cycle();
        t_sw_stop();
        t_arm_while_stopped();
        t_loss();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule